// File: doc/BRIEF.md
# Out-of-Order Issue Queue with Write-Port Scheduling

This block holds decoded instructions for a single-issue core that issues out of order and has no register renaming. Decode pushes at most one instruction per cycle, in program order, into a 16-slot queue. Each cycle the block picks at most one instruction whose operands are available and whose issue breaks no ordering rule. It sends that instruction to the pipe that executes its class: X for ALU and branch work, M for memory access, Y for multiplies.

The register file has a single write port. Issue is therefore also a booking: an instruction that writes a register may only leave when the cycle in which its result will come back is still free. A five-slot reservation shift register tracks the cycles already booked. A pending-write countdown per architectural register provides the dependency state. Because there is no renaming, false dependencies (write-after-read, write-after-write) hold instructions back just as true ones do. When every slot is taken, a full flag stalls decode.

Top module: `ooo_issue_queue`

## Requirements
- R1: After reset the queue is empty: `q_full` is 0 and `iss_valid` is 0 until an instruction has been entered.
- R2: Each instruction accepted through `in_valid` (while `q_full` is 0) appears exactly once on the issue port with its kind, destination, sources and tag unchanged, and at most one instruction appears per cycle. An instruction can appear on the issue port at the earliest two cycles after the edge that accepts it.
- R3: Kind encoding `in_kind`: 0 = ALU/branch, 1 = load, 2 = store, 3 = multiply. Pipe encoding `iss_pipe`: 0 = X, 1 = M, 2 = Y. ALU goes to X with latency 1, load and store go to M with latency 2, multiply goes to Y with latency 4.
- R4: An instruction writes a register (`iss_wen` = 1) unless it is a store or its destination is register 0. A writing instruction shown on the issue port in cycle t writes back in cycle t + latency, and no two writing instructions share a writeback cycle. Instructions that do not write book no slot: after a multiply and an ALU op issued back to back, a following load is delayed by one cycle but a following store is not.
- R5: A consumer reading register r (r != 0) appears no earlier than its producer's cycle plus the producer's latency, so that a dependent ALU op can follow its ALU producer in the very next cycle and follows a multiply four cycles later.
- R6: An instruction writing register r does not appear before every older instruction that reads r has appeared.
- R7: An instruction writing register r does not appear before the writeback cycle of every older instruction writing r.
- R8: Among instructions free to issue, the oldest goes first. A younger independent instruction passes an older blocked one.
- R9: `q_full` is 1 exactly when 16 instructions are held. While it is 1, `in_valid` is ignored, even in a cycle in which an entry issues. The freed entry accepts an instruction from the next cycle on.
- R10: Register 0 is never a dependency. Reading it never waits, and naming it as a destination books nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decode offers an instruction this cycle |
| in_kind | input | 2 | Instruction class (R3 encoding) |
| in_dst | input | REG_W | Destination register |
| in_src1 | input | REG_W | First source register |
| in_src2 | input | REG_W | Second source register |
| in_tag | input | TAG_W | Opaque identifier carried to the issue port |
| q_full | output | 1 | All slots occupied, decode must hold |
| iss_valid | output | 1 | An instruction is issued this cycle |
| iss_pipe | output | 2 | Target pipe (R3 encoding) |
| iss_kind | output | 2 | Class of issued instruction |
| iss_dst | output | REG_W | Destination of issued instruction |
| iss_src1 | output | REG_W | First source of issued instruction |
| iss_src2 | output | REG_W | Second source of issued instruction |
| iss_tag | output | TAG_W | Tag of issued instruction |
| iss_wen | output | 1 | Issued instruction will write the register file |

## Verification
A stale countdown or a missed reservation bit shows on the issue port within four cycles: two writers land on the same writeback cycle, or a consumer comes out before its producer's latency has elapsed. A wrong compaction of the queue shows as a lost, repeated or altered tag the next time the affected slot issues. A wrong occupancy count shows as `q_full` disagreeing with the number of instructions accepted minus those issued, in the very cycle after the edge. Directed sequences pin exact issue cycles for bypass, slot conflicts, false dependencies and age order. A long random stream with a small register set then checks every ordering relation between each issued instruction and its older neighbours.

// File: rtl/iq_pkg.sv
package iq_pkg;

    typedef enum logic [1:0] {
        OP_ALU   = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STORE = 2'd2,
        OP_MUL   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PIPE_X = 2'd0,
        PIPE_M = 2'd1,
        PIPE_Y = 2'd2
    } pipe_e;

    localparam int LAT_ALU  = 1;
    localparam int LAT_MEM  = 2;
    localparam int LAT_MUL  = 4;
    localparam int LAT_W    = $clog2(LAT_MUL + 1);
    localparam int SLOT_W   = LAT_MUL + 1;

    function automatic logic [LAT_W-1:0] op_latency(input logic [1:0] op);
        case (op)
            OP_ALU:  return LAT_W'(LAT_ALU);
            OP_MUL:  return LAT_W'(LAT_MUL);
            default: return LAT_W'(LAT_MEM);
        endcase
    endfunction

    function automatic logic [1:0] op_pipe(input logic [1:0] op);
        case (op)
            OP_ALU:  return PIPE_X;
            OP_MUL:  return PIPE_Y;
            default: return PIPE_M;
        endcase
    endfunction

endpackage

// File: rtl/iq_scoreboard.sv
module iq_scoreboard
    import iq_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int REG_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [REG_W-1:0]  set_reg,
    input  logic [LAT_W-1:0]  set_lat,
    output logic [NREG-1:0]   reg_pend,
    output logic [SLOT_W-1:0] slot_busy
);

    typedef struct packed {
        logic [NREG-1:0][LAT_W-1:0] cnt;
        logic [SLOT_W-1:0]          slot;
    } sb_t;

    sb_t sb_d, sb_q;

    always_comb begin
        sb_d = sb_q;
        for (int r = 0; r < NREG; r++) begin
            sb_d.cnt[r] = (sb_q.cnt[r] != '0) ? sb_q.cnt[r] - LAT_W'(1) : '0;
        end
        sb_d.slot = sb_q.slot >> 1;
        if (set_en) begin
            sb_d.cnt[set_reg]                  = set_lat;
            sb_d.slot[set_lat - LAT_W'(1)]     = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sb_q <= '0;
        else        sb_q <= sb_d;
    end

    always_comb begin
        for (int r = 0; r < NREG; r++) begin
            reg_pend[r] = sb_q.cnt[r] > LAT_W'(1);
        end
    end

    assign slot_busy = sb_q.slot;

    // R4: the booking made on issue is visible one cycle later, shifted by one
    p_slot_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> slot_busy[$past(set_lat) - LAT_W'(1)]);

    // R4: the hazard filter never lets a writer take an already booked slot
    p_slot_unique_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !slot_busy[set_lat]);

    // R7: a multi-cycle writer marks its destination pending
    p_dest_marked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && set_lat > LAT_W'(1)) |=> reg_pend[$past(set_reg)]);

endmodule

// File: rtl/iq_hazard.sv
module iq_hazard
    import iq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int NREG  = 32,
    parameter int REG_W = $clog2(NREG)
) (
    input  logic [DEPTH-1:0]            valid,
    input  logic [DEPTH-1:0][1:0]       op,
    input  logic [DEPTH-1:0][REG_W-1:0] dst,
    input  logic [DEPTH-1:0][REG_W-1:0] src1,
    input  logic [DEPTH-1:0][REG_W-1:0] src2,
    input  logic [NREG-1:0]             reg_pend,
    input  logic [SLOT_W-1:0]           slot_busy,
    output logic [DEPTH-1:0]            elig
);

    logic [DEPTH-1:0] wr_v;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            wr_v[i] = valid[i] && (op[i] != OP_STORE) && (dst[i] != '0);
        end
    end

    always_comb begin
        elig = valid;
        for (int i = 0; i < DEPTH; i++) begin
            // in-flight producers and writers
            if (src1[i] != '0 && reg_pend[src1[i]]) elig[i] = 1'b0;
            if (src2[i] != '0 && reg_pend[src2[i]]) elig[i] = 1'b0;
            if (wr_v[i] && reg_pend[dst[i]])        elig[i] = 1'b0;
            // write-port booking
            if (wr_v[i] && slot_busy[op_latency(op[i])]) elig[i] = 1'b0;
            // older queued instructions
            for (int j = 0; j < DEPTH; j++) begin
                if (j < i && valid[j]) begin
                    if (wr_v[j] && src1[i] != '0 && dst[j] == src1[i]) elig[i] = 1'b0;
                    if (wr_v[j] && src2[i] != '0 && dst[j] == src2[i]) elig[i] = 1'b0;
                    if (wr_v[i] && wr_v[j] && dst[j] == dst[i])        elig[i] = 1'b0;
                    if (wr_v[i] && (src1[j] == dst[i] || src2[j] == dst[i])) elig[i] = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/iq_pick.sv
module iq_pick #(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] elig,
    output logic [DEPTH-1:0] grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    always_comb begin
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (elig[i]) idx = IDX_W'(i);
        end
        any   = |elig;
        grant = any ? (DEPTH'(1) << idx) : '0;
    end

    // R2: never more than one slot leaves per cycle
    p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R8: no eligible entry older than the chosen one is skipped
    p_oldest_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (elig[idx] && ((elig & ((DEPTH'(1) << idx) - DEPTH'(1))) == '0)));

endmodule

// File: rtl/ooo_issue_queue.sv
module ooo_issue_queue
    import iq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int NREG  = 32,
    parameter int REG_W = $clog2(NREG),
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       in_kind,
    input  logic [REG_W-1:0] in_dst,
    input  logic [REG_W-1:0] in_src1,
    input  logic [REG_W-1:0] in_src2,
    input  logic [TAG_W-1:0] in_tag,
    output logic             q_full,
    output logic             iss_valid,
    output logic [1:0]       iss_pipe,
    output logic [1:0]       iss_kind,
    output logic [REG_W-1:0] iss_dst,
    output logic [REG_W-1:0] iss_src1,
    output logic [REG_W-1:0] iss_src2,
    output logic [TAG_W-1:0] iss_tag,
    output logic             iss_wen
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [1:0]       op;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src1;
        logic [REG_W-1:0] src2;
        logic [TAG_W-1:0] tag;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0] count;
        logic             iss_v;
        ent_t             iss;
    } st_t;

    st_t st_d, st_q;

    logic [DEPTH-1:0]            valid_v;
    logic [DEPTH-1:0][1:0]       op_v;
    logic [DEPTH-1:0][REG_W-1:0] dst_v, src1_v, src2_v;
    logic [DEPTH-1:0]            elig, grant;
    logic [IDX_W-1:0]            pick_idx;
    logic                        pick_any;
    logic [NREG-1:0]             reg_pend;
    logic [SLOT_W-1:0]           slot_busy;
    logic                        set_en;
    ent_t                        picked;
    logic [CNT_W-1:0]            cnt_left;
    logic                        take;

    for (genvar i = 0; i < DEPTH; i++) begin : g_flat
        assign valid_v[i] = CNT_W'(i) < st_q.count;
        assign op_v[i]    = st_q.ent[i].op;
        assign dst_v[i]   = st_q.ent[i].dst;
        assign src1_v[i]  = st_q.ent[i].src1;
        assign src2_v[i]  = st_q.ent[i].src2;
    end

    iq_hazard #(.DEPTH(DEPTH), .NREG(NREG), .REG_W(REG_W)) u_hazard (
        .valid     (valid_v),
        .op        (op_v),
        .dst       (dst_v),
        .src1      (src1_v),
        .src2      (src2_v),
        .reg_pend  (reg_pend),
        .slot_busy (slot_busy),
        .elig      (elig)
    );

    iq_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .elig  (elig),
        .grant (grant),
        .idx   (pick_idx),
        .any   (pick_any)
    );

    assign picked = st_q.ent[pick_idx];
    assign set_en = pick_any && (picked.op != OP_STORE) && (picked.dst != '0);

    iq_scoreboard #(.NREG(NREG), .REG_W(REG_W)) u_sb (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (set_en),
        .set_reg   (picked.dst),
        .set_lat   (op_latency(picked.op)),
        .reg_pend  (reg_pend),
        .slot_busy (slot_busy)
    );

    assign q_full = st_q.count == CNT_W'(DEPTH);

    always_comb begin
        st_d       = st_q;
        st_d.iss_v = pick_any;
        st_d.iss   = picked;
        cnt_left   = st_q.count - CNT_W'(pick_any);
        if (pick_any) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IDX_W'(i) >= pick_idx) st_d.ent[i] = st_q.ent[i + 1];
            end
        end
        take = in_valid && !q_full;
        if (take) begin
            st_d.ent[cnt_left[IDX_W-1:0]] = '{op: in_kind, dst: in_dst,
                                              src1: in_src1, src2: in_src2, tag: in_tag};
        end
        st_d.count = cnt_left + CNT_W'(take);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign iss_valid = st_q.iss_v;
    assign iss_kind  = st_q.iss.op;
    assign iss_pipe  = op_pipe(st_q.iss.op);
    assign iss_dst   = st_q.iss.dst;
    assign iss_src1  = st_q.iss.src1;
    assign iss_src2  = st_q.iss.src2;
    assign iss_tag   = st_q.iss.tag;
    assign iss_wen   = st_q.iss_v && (st_q.iss.op != OP_STORE) && (st_q.iss.dst != '0);

    // R9: occupancy never exceeds the slot count
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH));

    // R9: an offer while full never grows the queue
    p_full_refuses_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && in_valid) |=> st_q.count <= $past(st_q.count));

    // R2: a grant only comes from an occupied slot
    p_grant_occupied_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pick_any |-> valid_v[pick_idx]);

endmodule

// File: tb/ooo_issue_queue_test.sv
module ooo_issue_queue_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DEPTH = 16;
    localparam int REG_W = 5;
    localparam int TAG_W = 8;
    localparam int MAXI  = 2048;
    localparam int WD    = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [1:0] in_kind = '0;
    logic [REG_W-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic [TAG_W-1:0] in_tag = '0;
    logic q_full, iss_valid, iss_wen;
    logic [1:0] iss_pipe, iss_kind;
    logic [REG_W-1:0] iss_dst, iss_src1, iss_src2;
    logic [TAG_W-1:0] iss_tag;

    always #10 clk = ~clk;

    ooo_issue_queue uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .in_tag(in_tag),
        .q_full(q_full), .iss_valid(iss_valid), .iss_pipe(iss_pipe),
        .iss_kind(iss_kind), .iss_dst(iss_dst), .iss_src1(iss_src1),
        .iss_src2(iss_src2), .iss_tag(iss_tag), .iss_wen(iss_wen)
    );

    int total = 0, bad = 0;
    int cyc = 0;
    int p_op[MAXI], p_dst[MAXI], p_s1[MAXI], p_s2[MAXI], port[MAXI];
    bit issued[MAXI];
    int prog_len = 0, next_id = 0, tail = 0, occ = 0, offer_pct = 100;
    bit off_v = 0, off_full = 0, saw_full = 0;
    bit wb_used[int];

    function automatic int lat_of(int op);
        return (op == 0) ? 1 : (op == 3) ? 4 : 2;
    endfunction
    function automatic int pipe_of(int op);
        return (op == 0) ? 0 : (op == 3) ? 2 : 1;
    endfunction
    function automatic bit writes(int op, int dst);
        return (op != 2) && (dst != 0);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int add(int op, int dst, int s1, int s2);
        p_op[prog_len] = op; p_dst[prog_len] = dst;
        p_s1[prog_len] = s1; p_s2[prog_len] = s2;
        prog_len++;
        return prog_len - 1;
    endfunction

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic handle_issue();
        int id = -1;
        for (int k = tail; k < next_id; k++) begin
            if (id < 0 && !issued[k] && (k % 256) == int'(iss_tag)) id = k;
        end
        chk(id >= 0, "R2 tag of an accepted, unissued instruction", int'(iss_tag), 0);
        if (id < 0) return;
        issued[id] = 1; port[id] = cyc; occ--;
        while (tail < next_id && issued[tail]) tail++;
        chk(int'(iss_kind) == p_op[id] && int'(iss_dst) == p_dst[id] &&
            int'(iss_src1) == p_s1[id] && int'(iss_src2) == p_s2[id],
            "R2 fields carried", int'(iss_dst), p_dst[id]);
        chk(int'(iss_pipe) == pipe_of(p_op[id]), "R3 pipe", int'(iss_pipe), pipe_of(p_op[id]));
        chk(iss_wen == writes(p_op[id], p_dst[id]), "R4/R10 write enable",
            int'(iss_wen), int'(writes(p_op[id], p_dst[id])));
        if (writes(p_op[id], p_dst[id])) begin
            int wb = cyc + lat_of(p_op[id]);
            chk(!wb_used.exists(wb), "R4 writeback cycle unique", wb, -1);
            wb_used[wb] = 1;
        end
        for (int j = (id > 48 ? id - 48 : 0); j < id; j++) begin
            bit wj = writes(p_op[j], p_dst[j]);
            int rdy = issued[j] ? port[j] + lat_of(p_op[j]) : 1 << 30;
            if (wj && ((p_s1[id] != 0 && p_s1[id] == p_dst[j]) ||
                       (p_s2[id] != 0 && p_s2[id] == p_dst[j])))
                chk(rdy <= cyc, "R5 consumer after producer latency", cyc, rdy);
            if (writes(p_op[id], p_dst[id]) && (p_s1[j] == p_dst[id] || p_s2[j] == p_dst[id]))
                chk(issued[j] && port[j] < cyc, "R6 writer after older reader", cyc,
                    issued[j] ? port[j] + 1 : -1);
            if (wj && writes(p_op[id], p_dst[id]) && p_dst[j] == p_dst[id])
                chk(rdy <= cyc, "R7 writer after older writer writeback", cyc, rdy);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        if (off_v && !off_full) begin next_id++; occ++; end
        if (iss_valid) handle_issue();
        chk(q_full == (occ == DEPTH), "R9 full flag vs occupancy", int'(q_full), int'(occ == DEPTH));
        if (q_full) saw_full = 1;
        if (cyc > WD) begin
            chk(0, "R2 watchdog", cyc, WD);
            summary();
        end
        off_v = 0;
        if (next_id < prog_len && ($urandom % 100) < offer_pct) begin
            off_v   = 1;
            in_kind = p_op[next_id][1:0];
            in_dst  = p_dst[next_id][REG_W-1:0];
            in_src1 = p_s1[next_id][REG_W-1:0];
            in_src2 = p_s2[next_id][REG_W-1:0];
            in_tag  = next_id[TAG_W-1:0];
        end
        in_valid = off_v;
        off_full = q_full;
    endtask

    task automatic run_all();
        while (tail < prog_len) step();
        step(); step(); step(); step(); step();
    endtask

    initial begin
        int a, b, c;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!iss_valid && !q_full, "R1 state during reset", int'(iss_valid), 0);
        rst_n = 1'b1;
        step();
        chk(!iss_valid && !q_full, "R1 empty after reset", int'(q_full), 0);
        step();
        chk(!iss_valid, "R1 nothing issued while empty", int'(iss_valid), 0);

        // R5: ALU bypass back to back, multiply four cycles
        a = add(0, 1, 2, 3); b = add(0, 4, 1, 0);
        run_all();
        chk(port[b] - port[a] == 1, "R5 ALU dependent next cycle", port[b] - port[a], 1);
        a = add(3, 5, 2, 3); b = add(0, 6, 5, 0);
        run_all();
        chk(port[b] - port[a] == 4, "R5 multiply dependent gap", port[b] - port[a], 4);

        // R4: load collides with multiply writeback, store does not
        a = add(3, 1, 2, 3); b = add(0, 2, 0, 0); c = add(1, 3, 4, 0);
        run_all();
        chk(port[c] - port[a] == 3, "R4 load pushed off booked slot", port[c] - port[a], 3);
        a = add(3, 1, 2, 3); b = add(0, 2, 0, 0); c = add(2, 0, 4, 5);
        run_all();
        chk(port[c] - port[a] == 2, "R4 store books no slot", port[c] - port[a], 2);

        // R8: younger independent passes; equal readiness resolves oldest first
        a = add(3, 1, 2, 3); b = add(0, 2, 1, 0); c = add(0, 3, 4, 0);
        run_all();
        chk(port[c] - port[a] == 2, "R8 younger passes blocked", port[c] - port[a], 2);
        chk(port[b] - port[a] == 4, "R8 blocked waits for producer", port[b] - port[a], 4);
        a = add(3, 1, 2, 3); b = add(0, 2, 1, 0); c = add(0, 3, 1, 0);
        run_all();
        chk(port[b] - port[a] == 4 && port[c] - port[a] == 5, "R8 oldest first",
            port[c] - port[a], 5);

        // R6: write-after-read holds the writer until the reader leaves
        a = add(3, 5, 2, 3); b = add(0, 6, 5, 7); c = add(0, 7, 0, 0);
        run_all();
        chk(port[c] - port[a] == 5, "R6 false dependency stall", port[c] - port[a], 5);

        // R7: write-after-write waits for the older writeback
        a = add(3, 1, 2, 3); b = add(0, 1, 0, 0);
        run_all();
        chk(port[b] - port[a] == 4, "R7 second writer gap", port[b] - port[a], 4);

        // R10: register 0 as destination and source carries no dependency
        a = add(3, 0, 2, 3); b = add(0, 2, 0, 0);
        run_all();
        chk(port[b] - port[a] == 1, "R10 r0 no wait", port[b] - port[a], 1);

        // R9: long multiply chain fills the queue
        for (int k = 0; k < 30; k++) a = add(3, 1, 1, 1);
        run_all();
        chk(saw_full, "R9 full reached", int'(saw_full), 1);

        // random stream, small register set
        offer_pct = 75;
        while (prog_len < 1400) begin
            int op = int'($urandom % 4);
            a = add(op, int'($urandom % 8), int'($urandom % 8), (op == 1) ? 0 : int'($urandom % 8));
        end
        run_all();
        chk(tail == prog_len, "R2 every accepted instruction issued", tail, prog_len);
        chk(occ == 0 && !q_full, "R9 empty after drain", occ, 0);
        summary();
    end

endmodule